// File: doc/BRIEF.md
# Self-Relocating Peripheral Register Window Decoder

This block watches processor bus cycles and decides whether each one falls inside a 256-byte window of on-chip peripheral control registers. When a cycle hits, it reports a hit flag and the byte offset into the window, so that downstream register logic can select its target. The window's base address comes from a 16-bit relocation register. That register is one of the registers inside the window, so software can move the window by writing to it.

The relocation register holds three things: the base page, a flag that places the window in memory space or in I/O space, and a mode bit passed to the interrupt controller. In I/O space only 16 address bits are significant, so the top four base bits are left out of the comparison. Reads of the relocation register come back on the block's read-data output. Every other offset only produces hit and offset, and the addressed register outside this block answers the cycle.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the relocation register reads 20FFh: the window is in I/O space with base FF00h, and `slave_mode_o` is 0.
- R2: When register bit 12 is 1, a memory cycle (`mem_cycle_i`=1) hits exactly when address bits 19:8 equal register bits 11:0.
- R3: When register bit 12 is 0, an I/O cycle (`mem_cycle_i`=0) hits exactly when address bits 15:8 equal register bits 7:0. Address bits 19:16 and register bits 11:8 have no effect on the result.
- R4: A cycle whose type does not match the space selected by register bit 12 never hits.
- R5: `offset_o` equals address bits 7:0 while `hit_o` is 1 and is 0 otherwise. Hit and offset follow the address combinationally.
- R6: With `rd_i`=1, a hit and offset FEh, `rdata_o` shows the relocation register. In every other case `rdata_o` is 0.
- R7: `wr_i`=1 with a hit at offset FEh loads the relocation register on the next rising clock edge. Bits 14, 12 and 11:0 come from `wdata_i`. Bit 15 always reads 0 and bit 13 always reads 1, whatever is written.
- R8: The write cycle that changes the register is decoded against the old base and space. The new mapping applies from the cycle after the clock edge.
- R9: A write at any other offset, outside the window, or with a cycle type that does not match the space leaves the register unchanged.
- R10: `slave_mode_o` follows register bit 14: 1 selects slave mode and 0 selects master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Bus cycle address |
| mem_cycle_i | input | 1 | Cycle type: 1 memory, 0 I/O |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| hit_o | output | 1 | Cycle falls inside the window |
| offset_o | output | 8 | Byte offset into the window |
| rdata_o | output | 16 | Relocation register read data |
| slave_mode_o | output | 1 | Interrupt controller mode (1 slave, 0 master) |

## Verification
The hardest situation to reach is the cycle in which the window moves. In that cycle the address that selects the register must still decode against the old mapping, and one edge later the same address must miss. The stimulus reaches it by issuing relocation writes from the current window location and checking the hit before the clock edge and again after it. It also uses an I/O-space base that has a nonzero upper nibble, together with write addresses whose upper nibble differs from the base's. Around each relocation, every 256-byte page is swept under both cycle types, so the decode is checked against the whole address space and not only near the base.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int ADDR_W    = 20;
  localparam int OFS_W     = 8;
  localparam int DATA_W    = 16;
  localparam int IO_ADDR_W = 16;
  localparam int PAGE_W    = ADDR_W - OFS_W;
  localparam int SPACE_BIT = 12;
  localparam int MODE_BIT  = 14;

  localparam logic [DATA_W-1:0] RELOC_RST = 16'h20FF;
  localparam logic [OFS_W-1:0]  RELOC_OFS = 8'hFE;
  // writable fields: mode, space, base page
  localparam logic [DATA_W-1:0] WR_MASK =
    DATA_W'((1 << MODE_BIT) | (1 << SPACE_BIT) | ((1 << PAGE_W) - 1));

  typedef struct packed {
    logic              slave_mode;
    logic              mem_space;
    logic [PAGE_W-1:0] base;
  } reloc_t;

  function automatic reloc_t unpack_reloc(logic [DATA_W-1:0] r);
    reloc_t f;
    f.slave_mode = r[MODE_BIT];
    f.mem_space  = r[SPACE_BIT];
    f.base       = r[PAGE_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/regwin_reloc_reg.sv
module regwin_reloc_reg #(
  parameter int                DATA_W  = 16,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] WR_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  // non-writable bits stay pinned to their reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= (wdata_i & WR_MASK) | (RST_VAL & ~WR_MASK);
  end

  assign q_o = q;
endmodule

// File: rtl/regwin_match.sv
module regwin_match #(
  parameter int ADDR_W    = 20,
  parameter int OFS_W     = 8,
  parameter int IO_ADDR_W = 16,
  localparam int PAGE_W   = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_cycle_i,
  input  logic              mem_space_i,
  input  logic [PAGE_W-1:0] base_i,
  output logic              hit_o,
  output logic [OFS_W-1:0]  offset_o
);
  logic [PAGE_W-1:0] bit_ok;

  for (genvar i = 0; i < PAGE_W; i++) begin : g_bit
    if (OFS_W + i < IO_ADDR_W) begin : g_always
      assign bit_ok[i] = (addr_i[OFS_W+i] == base_i[i]);
    end else begin : g_mem_only
      // beyond the I/O address width: compared in memory space only
      assign bit_ok[i] = !mem_space_i || (addr_i[OFS_W+i] == base_i[i]);
    end
  end

  assign hit_o    = (&bit_ok) && (mem_cycle_i == mem_space_i);
  assign offset_o = hit_o ? addr_i[OFS_W-1:0] : '0;
endmodule

// File: rtl/regwin_read_mux.sv
module regwin_read_mux #(
  parameter int               DATA_W  = 16,
  parameter int               OFS_W   = 8,
  parameter logic [OFS_W-1:0] REG_OFS = '1
) (
  input  logic              rd_i,
  input  logic              hit_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel;
  assign sel     = rd_i && hit_i && (offset_i == REG_OFS);
  assign rdata_o = sel ? reg_i : '0;
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mem_cycle_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              slave_mode_o
);
  logic [DATA_W-1:0] reg_q;
  reloc_t            fld;
  logic              hit;
  logic [OFS_W-1:0]  offset;
  logic              reg_we;

  assign fld    = unpack_reloc(reg_q);
  assign reg_we = wr_i && hit && (offset == RELOC_OFS);

  regwin_reloc_reg #(
    .DATA_W (DATA_W),
    .RST_VAL(RELOC_RST),
    .WR_MASK(WR_MASK)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .wdata_i(wdata_i),
    .q_o    (reg_q)
  );

  regwin_match #(
    .ADDR_W   (ADDR_W),
    .OFS_W    (OFS_W),
    .IO_ADDR_W(IO_ADDR_W)
  ) u_match (
    .addr_i     (addr_i),
    .mem_cycle_i(mem_cycle_i),
    .mem_space_i(fld.mem_space),
    .base_i     (fld.base),
    .hit_o      (hit),
    .offset_o   (offset)
  );

  regwin_read_mux #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .REG_OFS(RELOC_OFS)
  ) u_rmux (
    .rd_i    (rd_i),
    .hit_i   (hit),
    .offset_i(offset),
    .reg_i   (reg_q),
    .rdata_o (rdata_o)
  );

  assign hit_o        = hit;
  assign offset_o     = offset;
  assign slave_mode_o = fld.slave_mode;
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk
  import regwin_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mem_cycle_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              hit_o,
  input logic [OFS_W-1:0]  offset_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              slave_mode_o,
  input logic [DATA_W-1:0] reg_q
);
  p_mem_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mem_cycle_i) |-> (reg_q[SPACE_BIT] && addr_i[ADDR_W-1:OFS_W] == reg_q[PAGE_W-1:0]));

  p_io_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !mem_cycle_i) |-> (!reg_q[SPACE_BIT] &&
      addr_i[IO_ADDR_W-1:OFS_W] == reg_q[IO_ADDR_W-OFS_W-1:0]));

  p_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o == addr_i[OFS_W-1:0]));

  p_offset_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (offset_o == '0));

  p_rdata_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && hit_o) |-> (rdata_o == '0));

  p_write_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_o && offset_o == RELOC_OFS) |=>
      (slave_mode_o == $past(wdata_i[MODE_BIT]) &&
       reg_q[SPACE_BIT] == $past(wdata_i[SPACE_BIT]) &&
       reg_q[PAGE_W-1:0] == $past(wdata_i[PAGE_W-1:0])));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit_o && offset_o == RELOC_OFS) |=> $stable(reg_q));
endmodule

bind regwin_decoder regwin_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .mem_cycle_i (mem_cycle_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .hit_o       (hit_o),
  .offset_o    (offset_o),
  .rdata_o     (rdata_o),
  .slave_mode_o(slave_mode_o),
  .reg_q       (reg_q)
);

// File: tb/regwin_decoder_test.sv
module regwin_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        memc = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        hit;
  logic [7:0]  offset;
  logic [15:0] rdata;
  logic        slave;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_reg = 16'h20FF;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mem_cycle_i(memc),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .hit_o(hit), .offset_o(offset), .rdata_o(rdata), .slave_mode_o(slave)
  );

  function automatic bit e_hit(logic [19:0] a, bit m);
    if (m != exp_reg[12]) return 1'b0;
    if (m) return a[19:8] == exp_reg[11:0];
    return a[15:8] == exp_reg[7:0];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(logic [19:0] a, bit m, bit r);
    bit          eh;
    logic [7:0]  eo;
    logic [15:0] ed;
    string       req;
    addr = a; memc = m; rd = r;
    #1;
    eh = e_hit(a, m);
    eo = eh ? a[7:0] : 8'h00;
    ed = (r && eh && a[7:0] == 8'hFE) ? exp_reg : 16'h0000;
    req = (m != exp_reg[12]) ? "R4" : (m ? "R2" : "R3");
    chk(hit == eh && offset == eo && rdata == ed, req,
        $sformatf("decode addr %h mem %0d rd %0d (R5 R6) hit/off/rdata", a, m, r),
        {7'd0, hit, offset, rdata}, {7'd0, eh, eo, ed});
  endtask

  task automatic sweep();
    for (int p = 0; p < 4096; p++) begin
      for (int m = 0; m < 2; m++) begin
        check_vec({p[11:0], 8'((p * 37 + m * 101) & 255)}, m[0], p[0]);
        check_vec({p[11:0], 8'hFE}, m[0], ~p[0]);
      end
    end
    rd = 1'b0;
  endtask

  // write cycle: hit checked against old mapping before the edge (R8)
  task automatic do_write(logic [19:0] a, bit m, logic [15:0] d);
    bit take;
    @(negedge clk);
    addr = a; memc = m; wdata = d; wr = 1'b1; rd = 1'b0;
    #1;
    take = e_hit(a, m) && a[7:0] == 8'hFE;
    chk(hit == e_hit(a, m), "R8", "hit during write cycle uses old base", 32'(hit), 32'(e_hit(a, m)));
    @(posedge clk);
    #1;
    wr = 1'b0;
    if (take) exp_reg = (d & 16'h5FFF) | 16'h2000;
  endtask

  task automatic read_back(string req);
    logic [19:0] a;
    a = exp_reg[12] ? {exp_reg[11:0], 8'hFE} : {4'h9, exp_reg[7:0], 8'hFE};
    addr = a; memc = exp_reg[12]; rd = 1'b1;
    #1;
    chk(hit && rdata == exp_reg, req, "relocation register read-back", {15'd0, hit, rdata}, {16'd1, exp_reg});
    chk(slave == exp_reg[14], "R10", "slave mode output", 32'(slave), 32'(exp_reg[14]));
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(slave == 1'b0, "R1", "slave mode during reset", 32'(slave), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    read_back("R1");
    check_vec(20'hFFF00, 1'b0, 1'b0); // R1 R3: upper nibble ignored at reset base
    sweep();

    // R9: writes that must not land
    do_write(20'h0FF00, 1'b0, 16'h5123);
    read_back("R9");
    do_write(20'h0FFFE, 1'b1, 16'h5123);
    read_back("R9");
    do_write(20'h000FE, 1'b0, 16'h5123);
    read_back("R9");

    // R7: relocate to memory space; reserved bits forced
    do_write(20'h0FFFE, 1'b0, 16'hD123);
    chk(exp_reg == 16'h7123, "R7", "bench model of masked write", 32'(exp_reg), 32'h7123);
    check_vec(20'h0FFFE, 1'b0, 1'b1); // R8: old location now misses
    read_back("R7");
    sweep();

    // R3: I/O space with nonzero upper base nibble
    do_write(20'h123FE, 1'b1, 16'h0A45);
    read_back("R7");
    sweep();

    // R3: write through alias with other upper nibble, back to reset value
    do_write(20'h345FE, 1'b0, 16'h20FF);
    read_back("R3");
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule